// File: doc/BRIEF.md
# MSI to Event Queue Controller

This block turns inbound message-signalled interrupt writes into records in memory-resident event queues. Each arriving MSI carries a number, a 32-bit or 64-bit format flag, a requester ID and the target address of the original write. The MSI number selects an entry in a mapping table. That entry says whether the MSI is usable, whether it is currently inhibited, and which event queue it feeds.

A usable MSI aimed at an active queue with room produces one 64-byte record. The record is written through a single-cycle memory write port at the queue's tail slot, and the tail then advances. The MSI is then inhibited, so that it cannot add more records until software re-arms it. Each queue drives an interrupt line while it is active and holds undrained records.

A queue that would fill up stops accepting records. It raises an overflow flag and enters an error state, and software has to clear both. Software programs the mapping table, re-arms MSIs, enables and disables queues, and reads or writes the head and tail pointers through a simple word-wide register port.

Top module: `msi_eq_ctrl`

## Requirements
- R1: After reset every queue reads state 1 (idle), head 0, tail 0 and overflow 0. Every mapping entry reads 0, no memory write is issued, and all queue interrupts are low.
- R2: Register addressing uses byte address bits [11:8] for the register class and bits [7:3] for the MSI or queue index. The classes are: 0 mapping entry, 1 MSI clear, 2 queue set-control, 3 queue clear-control, 4 queue state, 5 tail, 6 head. A mapping entry holds valid at bit 63, inhibit at bit 62 and target queue at bits 5:0, and it reads back with all other bits zero.
- R3: An MSI whose entry is valid and not inhibited, and whose queue is active and not full, makes the block pulse mem_wr in the cycle after msi_vld is sampled. The write goes to address QBASE + queue*QREGION + tail*64, and that queue's tail advances by one.
- R4: Record word 0 is in mem_data[63:0]. It holds bit 63 = 0, type at bits 62:59 (0xB for a 32-bit MSI, 0xF for a 64-bit MSI), format bits 58:56 = 0, length bits 55:46 = 1, msi_addr[15:2] at bits 45:32, the requester ID at bits 31:16 and the MSI number at bits 15:0. Word 1 is in mem_data[127:64] and holds msi_addr[63:16] in its bits 63:16 with 0 in bits 15:0. mem_data[511:128] is zero.
- R5: A record sets that MSI's inhibit bit, and further MSIs with that number produce no record and leave the tail unchanged. A write to the MSI clear register with bit 62 set clears the inhibit bit.
- R6: An MSI is dropped, with no record, no pointer change and no inhibit change, if its number is at least NUM_MSI, its entry is not valid, or its target queue is at least NUM_EQ.
- R7: An MSI whose target queue is not active (state 1 or 4) is dropped and does not set its inhibit bit.
- R8: When the tail advances from EQ_DEPTH-1 it wraps to 0.
- R9: A queue is full when the advanced tail would equal its head. An otherwise accepted MSI to a full queue issues no write, leaves the tail unchanged and does not set inhibit. It sets the overflow flag, read at tail register bit 57, and moves the queue to state 4 (error).
- R10: A clear-control write with bit 57 set clears the overflow flag, and one with bit 44 set returns the queue to state 1. A set-control write with bit 57 set sets the overflow flag.
- R11: eq_irq[q] is high exactly when queue q is in state 2 (active) and its head differs from its tail.
- R12: A set-control write with bit 44 set moves the queue to state 2. Software writes to the head and tail registers load bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_vld | input | 1 | MSI request present this cycle |
| msi_num | input | 16 | MSI number (write data) |
| msi_is64 | input | 1 | 1 = 64-bit address format |
| msi_rid | input | 16 | Requester ID |
| msi_addr | input | 64 | Address of the MSI write |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr (combinational) |
| mem_wr | output | 1 | Record write strobe |
| mem_addr | output | 64 | Record byte address |
| mem_data | output | 512 | Record contents |
| eq_irq | output | NUM_EQ | Per-queue interrupt |

## Verification
The bench targets the corner cases that are easy to get wrong. It checks that an MSI to an idle queue must not consume the inhibit latch, because a design that set the latch anyway would silently lose that MSI forever. It checks that the full test compares the advanced tail, not the current tail, against the head. A design that got this wrong would overwrite the oldest undrained slot, or would raise overflow one record too early. The bench also covers tail wrap at the configured depth, the inhibit re-arm path, out-of-range MSI and queue numbers, and the rule that an error-state queue keeps its interrupt low even while its head and tail differ.

// File: rtl/msi_eq_pkg.sv
package msi_eq_pkg;

  localparam logic [2:0] ST_IDLE   = 3'b001;
  localparam logic [2:0] ST_ACTIVE = 3'b010;
  localparam logic [2:0] ST_ERROR  = 3'b100;

  localparam logic [3:0] TYP_MSI32 = 4'hB;
  localparam logic [3:0] TYP_MSI64 = 4'hF;

  localparam logic [3:0] RC_MAP   = 4'd0;
  localparam logic [3:0] RC_CLR   = 4'd1;
  localparam logic [3:0] RC_SET   = 4'd2;
  localparam logic [3:0] RC_DIS   = 4'd3;
  localparam logic [3:0] RC_STATE = 4'd4;
  localparam logic [3:0] RC_TAIL  = 4'd5;
  localparam logic [3:0] RC_HEAD  = 4'd6;

  typedef struct packed {
    logic       vld;
    logic       inh;
    logic [5:0] qn;
  } map_ent_t;

  // next slot index, wrapping at the configured depth
  function automatic logic [6:0] ptr_next(input logic [6:0] p, input logic [7:0] depth);
    logic [7:0] n;
    n = {1'b0, p} + 8'd1;
    return (n >= depth) ? 7'd0 : n[6:0];
  endfunction

  function automatic logic [63:0] rec_word0(input logic is64, input logic [15:0] rid,
                                            input logic [15:0] num, input logic [13:0] abits);
    logic [3:0] typ;
    typ = is64 ? TYP_MSI64 : TYP_MSI32;
    return {1'b0, typ, 3'b000, 10'd1, abits, rid, num};
  endfunction

  function automatic logic [63:0] rec_word1(input logic [47:0] ahi);
    return {ahi, 16'd0};
  endfunction

  function automatic logic [63:0] rec_addr(input logic [63:0] base, input logic [63:0] region,
                                           input logic [5:0] q, input logic [6:0] slot);
    return base + region * {58'd0, q} + {51'd0, slot, 6'd0};
  endfunction

endpackage

// File: rtl/msi_map_table.sv
module msi_map_table
  import msi_eq_pkg::*;
#(
  parameter int NUM_MSI = 16,
  localparam int IW = (NUM_MSI > 1) ? $clog2(NUM_MSI) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  map_ent_t                  wr_ent,
  input  logic                      clr_en,
  input  logic [IW-1:0]             clr_idx,
  input  logic                      set_inh,
  input  logic [IW-1:0]             set_idx,
  output map_ent_t [NUM_MSI-1:0]    ents
);

  for (genvar i = 0; i < NUM_MSI; i++) begin : g_ent
    map_ent_t e_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_q <= '0;
      end else begin
        if (wr_en && wr_idx == IW'(i)) e_q <= wr_ent;
        if (clr_en && clr_idx == IW'(i)) e_q.inh <= 1'b0;
        if (set_inh && set_idx == IW'(i)) e_q.inh <= 1'b1;
      end
    end
    assign ents[i] = e_q;
  end

endmodule

// File: rtl/eq_bank.sv
module eq_bank
  import msi_eq_pkg::*;
#(
  parameter int NUM_EQ   = 4,
  parameter int EQ_DEPTH = 8,
  localparam int QW = (NUM_EQ > 1) ? $clog2(NUM_EQ) : 1,
  localparam logic [7:0] DEPTH8 = 8'(EQ_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     set_en,
  input  logic                     dis_en,
  input  logic                     tail_en,
  input  logic                     head_en,
  input  logic [QW-1:0]            widx,
  input  logic                     w_en_bit,
  input  logic                     w_ovf_bit,
  input  logic [6:0]               w_ptr,
  input  logic                     push_en,
  input  logic                     ovf_en,
  input  logic [QW-1:0]            hidx,
  output logic [NUM_EQ-1:0][2:0]   st,
  output logic [NUM_EQ-1:0][6:0]   head,
  output logic [NUM_EQ-1:0][6:0]   tail,
  output logic [NUM_EQ-1:0]        ovf,
  output logic [NUM_EQ-1:0]        irq
);

  for (genvar i = 0; i < NUM_EQ; i++) begin : g_q
    logic [2:0] st_q;
    logic [6:0] hd_q, tl_q;
    logic       of_q;
    logic       sw_hit, hw_hit;

    assign sw_hit = (widx == QW'(i));
    assign hw_hit = (hidx == QW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q <= ST_IDLE;
        hd_q <= '0;
        tl_q <= '0;
        of_q <= 1'b0;
      end else begin
        if (set_en && sw_hit) begin
          if (w_en_bit)  st_q <= ST_ACTIVE;
          if (w_ovf_bit) of_q <= 1'b1;
        end
        if (dis_en && sw_hit) begin
          if (w_en_bit)  st_q <= ST_IDLE;
          if (w_ovf_bit) of_q <= 1'b0;
        end
        if (tail_en && sw_hit) tl_q <= w_ptr;
        if (head_en && sw_hit) hd_q <= w_ptr;
        if (push_en && hw_hit) tl_q <= ptr_next(tl_q, DEPTH8);
        if (ovf_en && hw_hit) begin
          of_q <= 1'b1;
          st_q <= ST_ERROR;
        end
      end
    end

    assign st[i]   = st_q;
    assign head[i] = hd_q;
    assign tail[i] = tl_q;
    assign ovf[i]  = of_q;
    assign irq[i]  = (st_q == ST_ACTIVE) && (hd_q != tl_q);
  end

endmodule

// File: rtl/msi_rec_out.sv
module msi_rec_out
  import msi_eq_pkg::*;
#(
  parameter logic [63:0] QBASE   = 64'h0000_0001_0000_0000,
  parameter logic [63:0] QREGION = 64'h0000_0000_0000_2000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic         is64,
  input  logic [15:0]  rid,
  input  logic [15:0]  num,
  input  logic [63:0]  addr,
  input  logic [5:0]   q,
  input  logic [6:0]   slot,
  output logic         mem_wr,
  output logic [63:0]  mem_addr,
  output logic [511:0] mem_data
);

  logic [1:0] unused_addr_lsb;
  assign unused_addr_lsb = addr[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_wr   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_wr <= fire;
      if (fire) begin
        mem_addr <= rec_addr(QBASE, QREGION, q, slot);
        mem_data <= {384'd0, rec_word1(addr[63:16]), rec_word0(is64, rid, num, addr[15:2])};
      end
    end
  end

endmodule

// File: rtl/msi_eq_ctrl.sv
module msi_eq_ctrl
  import msi_eq_pkg::*;
#(
  parameter int          NUM_MSI  = 16,
  parameter int          NUM_EQ   = 4,
  parameter int          EQ_DEPTH = 8,
  parameter logic [63:0] QBASE    = 64'h0000_0001_0000_0000,
  parameter logic [63:0] QREGION  = 64'h0000_0000_0000_2000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 msi_vld,
  input  logic [15:0]          msi_num,
  input  logic                 msi_is64,
  input  logic [15:0]          msi_rid,
  input  logic [63:0]          msi_addr,
  input  logic                 reg_wr,
  input  logic [11:0]          reg_addr,
  input  logic [63:0]          reg_wdata,
  output logic [63:0]          reg_rdata,
  output logic                 mem_wr,
  output logic [63:0]          mem_addr,
  output logic [511:0]         mem_data,
  output logic [NUM_EQ-1:0]    eq_irq
);

  localparam int IW = (NUM_MSI > 1) ? $clog2(NUM_MSI) : 1;
  localparam int QW = (NUM_EQ > 1) ? $clog2(NUM_EQ) : 1;
  localparam logic [15:0] NMSI16 = 16'(NUM_MSI);
  localparam logic [5:0]  NEQ6   = 6'(NUM_EQ);
  localparam logic [7:0]  DEPTH8 = 8'(EQ_DEPTH);

  // register decode
  logic [3:0] r_cls;
  logic [4:0] r_idx;
  logic       r_msi_ok, r_q_ok;
  assign r_cls    = reg_addr[11:8];
  assign r_idx    = reg_addr[7:3];
  assign r_msi_ok = {11'd0, r_idx} < NMSI16;
  assign r_q_ok   = {1'b0, r_idx} < NEQ6;

  logic unused_bits;
  assign unused_bits = ^{reg_addr[2:0], reg_wdata[61:58], reg_wdata[56:45], reg_wdata[43:7]};

  // mapping table
  map_ent_t [NUM_MSI-1:0] ents;
  map_ent_t               wr_ent;
  map_ent_t               lk_ent;
  logic                   rec_fire, ovf_evt;
  logic [IW-1:0]          lk_idx;

  assign wr_ent = '{vld: reg_wdata[63], inh: reg_wdata[62], qn: reg_wdata[5:0]};
  assign lk_idx = msi_num[IW-1:0];

  msi_map_table #(.NUM_MSI(NUM_MSI)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr && r_cls == RC_MAP && r_msi_ok),
    .wr_idx  (r_idx[IW-1:0]),
    .wr_ent  (wr_ent),
    .clr_en  (reg_wr && r_cls == RC_CLR && r_msi_ok && reg_wdata[62]),
    .clr_idx (r_idx[IW-1:0]),
    .set_inh (rec_fire),
    .set_idx (lk_idx),
    .ents    (ents)
  );

  // queue bank
  logic [NUM_EQ-1:0][2:0] st;
  logic [NUM_EQ-1:0][6:0] head, tail;
  logic [NUM_EQ-1:0]      ovf;
  logic [QW-1:0]          hq;

  eq_bank #(.NUM_EQ(NUM_EQ), .EQ_DEPTH(EQ_DEPTH)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (reg_wr && r_cls == RC_SET  && r_q_ok),
    .dis_en    (reg_wr && r_cls == RC_DIS  && r_q_ok),
    .tail_en   (reg_wr && r_cls == RC_TAIL && r_q_ok),
    .head_en   (reg_wr && r_cls == RC_HEAD && r_q_ok),
    .widx      (r_idx[QW-1:0]),
    .w_en_bit  (reg_wdata[44]),
    .w_ovf_bit (reg_wdata[57]),
    .w_ptr     (reg_wdata[6:0]),
    .push_en   (rec_fire),
    .ovf_en    (ovf_evt),
    .hidx      (hq),
    .st        (st),
    .head      (head),
    .tail      (tail),
    .ovf       (ovf),
    .irq       (eq_irq)
  );

  // dispatch of an incoming MSI
  logic msi_in_rng, q_in_rng, q_active, q_full, accept;
  assign msi_in_rng = msi_num < NMSI16;
  assign lk_ent     = msi_in_rng ? ents[lk_idx] : '0;
  assign q_in_rng   = lk_ent.qn < NEQ6;
  assign hq         = lk_ent.qn[QW-1:0];
  assign q_active   = q_in_rng && (st[hq] == ST_ACTIVE);
  assign q_full     = ptr_next(tail[hq], DEPTH8) == head[hq];
  assign accept     = msi_vld && msi_in_rng && lk_ent.vld && !lk_ent.inh && q_active;
  assign rec_fire   = accept && !q_full;
  assign ovf_evt    = accept && q_full;

  msi_rec_out #(.QBASE(QBASE), .QREGION(QREGION)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (rec_fire),
    .is64     (msi_is64),
    .rid      (msi_rid),
    .num      (msi_num),
    .addr     (msi_addr),
    .q        (lk_ent.qn),
    .slot     (tail[hq]),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .mem_data (mem_data)
  );

  // register read
  map_ent_t rd_ent;
  logic [QW-1:0] rq;
  assign rd_ent = ents[r_idx[IW-1:0]];
  assign rq     = r_idx[QW-1:0];

  always_comb begin
    reg_rdata = '0;
    unique case (r_cls)
      RC_MAP:   if (r_msi_ok) reg_rdata = {rd_ent.vld, rd_ent.inh, 56'd0, rd_ent.qn};
      RC_STATE: if (r_q_ok)   reg_rdata = {61'd0, st[rq]};
      RC_TAIL:  if (r_q_ok)   reg_rdata = {6'd0, ovf[rq], 50'd0, tail[rq]};
      RC_HEAD:  if (r_q_ok)   reg_rdata = {57'd0, head[rq]};
      default:  reg_rdata = '0;
    endcase
  end

  // flattened view for the checker
  logic [NUM_EQ*3-1:0] st_flat;
  logic [NUM_EQ-1:0]   err_vec;
  for (genvar g = 0; g < NUM_EQ; g++) begin : g_flat
    assign st_flat[g*3 +: 3] = st[g];
    assign err_vec[g]        = st[g][2];
  end

endmodule

// File: rtl/msi_eq_chk.sv
module msi_eq_chk #(
  parameter int NUM_EQ = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  msi_vld,
  input logic                  rec_fire,
  input logic                  ovf_evt,
  input logic                  mem_wr,
  input logic [63:0]           word0,
  input logic [NUM_EQ*3-1:0]   st_flat,
  input logic [NUM_EQ-1:0]     err_vec,
  input logic [NUM_EQ-1:0]     irq
);

  AST_WR_NEEDS_MSI: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(msi_vld)); // R3

  AST_FIRE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    rec_fire |=> mem_wr); // R3

  AST_REC_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (word0[62:56] != 7'd0) && !word0[63]); // R4

  AST_OVF_TO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (|err_vec) && !mem_wr); // R9

  AST_FIRE_XOR_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_fire && ovf_evt)); // R9

  for (genvar i = 0; i < NUM_EQ; i++) begin : g_q
    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(st_flat[i*3 +: 3]) == 1); // R12

    AST_IRQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> (st_flat[i*3 +: 3] == 3'b010)); // R11
  end

endmodule

bind msi_eq_ctrl msi_eq_chk #(.NUM_EQ(NUM_EQ)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .msi_vld  (msi_vld),
  .rec_fire (rec_fire),
  .ovf_evt  (ovf_evt),
  .mem_wr   (mem_wr),
  .word0    (mem_data[63:0]),
  .st_flat  (st_flat),
  .err_vec  (err_vec),
  .irq      (eq_irq)
);

// File: tb/sim_msi_eq_ctrl.sv
module sim_msi_eq_ctrl;

  localparam logic [63:0] BASE   = 64'h0000_0001_0000_0000;
  localparam logic [63:0] REGION = 64'h0000_0000_0000_2000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         msi_vld = 1'b0;
  logic [15:0]  msi_num = '0;
  logic         msi_is64 = 1'b0;
  logic [15:0]  msi_rid = '0;
  logic [63:0]  msi_addr = '0;
  logic         reg_wr = 1'b0;
  logic [11:0]  reg_addr = '0;
  logic [63:0]  reg_wdata = '0;
  logic [63:0]  reg_rdata;
  logic         mem_wr;
  logic [63:0]  mem_addr;
  logic [511:0] mem_data;
  logic [3:0]   eq_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  msi_eq_ctrl #(.NUM_MSI(16), .NUM_EQ(4), .EQ_DEPTH(8), .QBASE(BASE), .QREGION(REGION)) u0 (
    .clk(clk), .rst_n(rst_n), .msi_vld(msi_vld), .msi_num(msi_num), .msi_is64(msi_is64),
    .msi_rid(msi_rid), .msi_addr(msi_addr), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_data(mem_data), .eq_irq(eq_irq)
  );

  function automatic logic [11:0] ra(input int cls, input int idx);
    return 12'((cls << 8) | (idx << 3));
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int cls, input int idx, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ra(cls, idx); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int cls, input int idx, output logic [63:0] d);
    @(negedge clk);
    reg_addr = ra(cls, idx);
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input string tag, input int cls, input int idx, input logic [63:0] exp);
    logic [63:0] v;
    rd(cls, idx, v);
    chk(tag, v, exp);
  endtask

  // sends one MSI; returns whether a write came out and its address/data
  task automatic send(input int num, input bit is64, input logic [15:0] rid, input logic [63:0] a,
                      output bit got, output logic [63:0] ga, output logic [127:0] gd);
    @(negedge clk);
    msi_vld = 1'b1; msi_num = 16'(num); msi_is64 = is64; msi_rid = rid; msi_addr = a;
    @(posedge clk);
    #1 got = mem_wr; ga = mem_addr; gd = mem_data[127:0];
    @(negedge clk);
    msi_vld = 1'b0;
  endtask

  function automatic logic [127:0] exp_rec(input int num, input bit is64, input logic [15:0] rid,
                                           input logic [63:0] a);
    logic [63:0] w0, w1;
    w0 = 64'(is64 ? 4'hF : 4'hB) << 59;
    w0 = w0 | (64'd1 << 46) | (64'(a[15:2]) << 32) | (64'(rid) << 16) | 64'(num);
    w1 = {a[63:16], 16'h0000};
    return {w1, w0};
  endfunction

  function automatic logic [63:0] map_val(input bit v, input bit inh, input int q);
    return (64'(v) << 63) | (64'(inh) << 62) | 64'(q);
  endfunction

  task automatic t_reset();
    for (int q = 0; q < 4; q++) begin
      rd_chk("R1 state", 4, q, 64'd1);
      rd_chk("R1 tail", 5, q, 64'd0);
      rd_chk("R1 head", 6, q, 64'd0);
    end
    rd_chk("R1 map", 0, 3, 64'd0);
    chk("R1 mem_wr", 64'(mem_wr), 64'd0);
    chk("R1 irq", 64'(eq_irq), 64'd0);
  endtask

  task automatic t_map_rw();
    wr(0, 3, map_val(1, 0, 2) | 64'h0000_0F00_0000_0F00);
    rd_chk("R2 map readback", 0, 3, map_val(1, 0, 2));
  endtask

  task automatic t_inactive();
    bit g; logic [63:0] a; logic [127:0] d;
    send(3, 0, 16'h1234, 64'h0, g, a, d);
    chk("R7 no write idle q", 64'(g), 64'd0);
    rd_chk("R7 inhibit untouched", 0, 3, map_val(1, 0, 2));
    rd_chk("R7 tail unchanged", 5, 2, 64'd0);
  endtask

  task automatic t_basic();
    bit g; logic [63:0] a; logic [127:0] d;
    logic [63:0] ad;
    wr(2, 2, 64'd1 << 44);
    rd_chk("R12 state active", 4, 2, 64'd2);
    chk("R11 irq empty q", 64'(eq_irq[2]), 64'd0);
    ad = 64'hABCD_EF01_2345_678C;
    send(3, 0, 16'h0A0B, ad, g, a, d);
    chk("R3 write issued", 64'(g), 64'd1);
    chk("R3 address", a, BASE + 2 * REGION);
    chk("R4 word0 32b", d[63:0], exp_rec(3, 0, 16'h0A0B, ad)[63:0]);
    chk("R4 word1", d[127:64], exp_rec(3, 0, 16'h0A0B, ad)[127:64]);
    chk("R4 upper zero", 64'(|mem_data[511:128]), 64'd0);
    rd_chk("R3 tail advanced", 5, 2, 64'd1);
    chk("R11 irq raised", 64'(eq_irq), 64'b0100);
    rd_chk("R5 inhibit set", 0, 3, map_val(1, 1, 2));
  endtask

  task automatic t_inhibit();
    bit g; logic [63:0] a; logic [127:0] d;
    send(3, 0, 16'h0A0B, 64'h0, g, a, d);
    chk("R5 repeat blocked", 64'(g), 64'd0);
    rd_chk("R5 tail held", 5, 2, 64'd1);
    wr(1, 3, 64'd1 << 61);
    rd_chk("R5 wrong bit no rearm", 0, 3, map_val(1, 1, 2));
    wr(1, 3, 64'd1 << 62);
    rd_chk("R5 rearmed", 0, 3, map_val(1, 0, 2));
    send(3, 1, 16'h7777, 64'h1111_2222_3333_4444, g, a, d);
    chk("R5 write after rearm", 64'(g), 64'd1);
    chk("R3 address slot1", a, BASE + 2 * REGION + 64);
    chk("R4 word0 64b", d[63:0], exp_rec(3, 1, 16'h7777, 64'h1111_2222_3333_4444)[63:0]);
    rd_chk("R3 tail 2", 5, 2, 64'd2);
  endtask

  task automatic t_irq_head();
    wr(6, 2, 64'd2);
    chk("R11 irq low drained", 64'(eq_irq[2]), 64'd0);
    rd_chk("R12 head write", 6, 2, 64'd2);
  endtask

  task automatic t_drops();
    bit g; logic [63:0] a; logic [127:0] d;
    wr(0, 6, map_val(1, 0, 9));
    send(5, 0, 16'h1, 64'h0, g, a, d);
    chk("R6 invalid entry", 64'(g), 64'd0);
    send(20, 0, 16'h1, 64'h0, g, a, d);
    chk("R6 msi out of range", 64'(g), 64'd0);
    send(6, 0, 16'h1, 64'h0, g, a, d);
    chk("R6 queue out of range", 64'(g), 64'd0);
    rd_chk("R6 map kept", 0, 6, map_val(1, 0, 9));
  endtask

  task automatic t_wrap();
    bit g; logic [63:0] a; logic [127:0] d;
    wr(0, 8, map_val(1, 0, 0));
    wr(2, 0, 64'd1 << 44);
    wr(6, 0, 64'd5);
    wr(5, 0, 64'd7);
    send(8, 0, 16'h2, 64'h40, g, a, d);
    chk("R8 write at last slot", 64'(g), 64'd1);
    chk("R8 address slot7", a, BASE + 7 * 64);
    rd_chk("R8 tail wrapped", 5, 0, 64'd0);
  endtask

  task automatic t_full();
    bit g; logic [63:0] a; logic [127:0] d;
    wr(0, 9, map_val(1, 0, 1));
    wr(2, 1, 64'd1 << 44);
    wr(5, 1, 64'd6);
    send(9, 0, 16'h3, 64'h0, g, a, d);
    chk("R9 last free slot", 64'(g), 64'd1);
    wr(1, 9, 64'd1 << 62);
    send(9, 0, 16'h3, 64'h0, g, a, d);
    chk("R9 full dropped", 64'(g), 64'd0);
    rd_chk("R9 error state", 4, 1, 64'd4);
    rd_chk("R9 ovf flag tail kept", 5, 1, (64'd1 << 57) | 64'd7);
    rd_chk("R9 inhibit not set", 0, 9, map_val(1, 0, 1));
    chk("R11 irq low in error", 64'(eq_irq[1]), 64'd0);
    wr(3, 1, 64'd1 << 57);
    rd_chk("R10 ovf cleared", 5, 1, 64'd7);
    rd_chk("R10 still error", 4, 1, 64'd4);
    wr(3, 1, 64'd1 << 44);
    rd_chk("R10 back to idle", 4, 1, 64'd1);
    wr(2, 1, 64'd1 << 57);
    rd_chk("R10 set ovf", 5, 1, (64'd1 << 57) | 64'd7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map_rw();
    t_inactive();
    t_basic();
    t_inhibit();
    t_irq_head();
    t_drops();
    t_wrap();
    t_full();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule